// File: doc/BRIEF.md
# Trap Cause Encoding and Delegation Unit

This block sits beside the execute stage of a small hart with machine, supervisor and user privilege. Each cycle it looks at the exception flags the pipeline raises, an environment-call request, and the interrupt lines that are already pending and enabled. If anything is present, it picks one trap and builds the cause word. It then decides whether the trap is handled by machine or by supervisor software. The decision uses a per-cause delegation mask and the current privilege. The block redirects the program counter to the chosen mode's vector base in the same cycle. On the following clock edge it records the cause, the faulting address and the previous privilege.

The block also executes the two trap-return operations. A machine return restores the privilege saved in the machine status field. A supervisor return restores the privilege saved in the supervisor previous-privilege bit. Each return redirects to the matching saved exception address. Software reaches the eight trap registers through a small indexed write port, and writes take effect on the next edge. The word width is a parameter that may be 32 or 64.

Top module: `trap_ctl`

## Requirements
- R1: After reset the privilege is machine (encoding 11). Both cause registers, both exception-address registers, the delegation mask and both vector bases are zero. The saved machine privilege is 00 and the saved supervisor bit is 0.
- R2: Among several exception flags raised together, exactly one is taken. The priority order, from highest, is: breakpoint (bit 3), instruction misaligned (bit 0), instruction access fault (bit 1), instruction page fault (bit 12), illegal instruction (bit 2), environment call, load misaligned (bit 4), store misaligned (bit 6), load page fault (bit 13), store page fault (bit 15), load access fault (bit 5), store access fault (bit 7). The code recorded is the bit number.
- R3: An environment call records code 8 when taken from user mode (00), 9 from supervisor mode (01) and 11 from machine mode (11).
- R4: An interrupt is taken only when no synchronous exception is present. When several interrupt lines are active, the highest line number wins. The cause word then has bit XLEN-1 set and the line number in the low bits.
- R5: A synchronous trap goes to supervisor mode when its code's bit in the delegation mask is set and the current privilege is not machine. Every other trap, including every interrupt, goes to machine mode. trap_s_o reports the target.
- R6: On a trap, the target mode's cause and exception-address registers take the cause word and pc_i, and the privilege becomes the target mode. A machine trap saves the old privilege in the 2-bit machine field. A supervisor trap saves bit 0 of the old privilege in the supervisor bit. Registers of the other mode are unchanged.
- R7: In the trap cycle, trap_o and redirect_o are high and target_pc_o equals the target mode's vector base. Vector bases are stored with their two low bits forced to zero.
- R8: A machine return with no trap in the same cycle sets the privilege to the saved machine field and clears that field to 00. It drives target_pc_o to the machine exception address.
- R9: A supervisor return with no trap or machine return in the same cycle sets the privilege to {0, saved supervisor bit} and clears that bit. It drives target_pc_o to the supervisor exception address.
- R10: Register writes are selected by csr_idx_i: 0 status (machine field from bits 12:11, supervisor bit from bit 8), 1 delegation mask, 2 machine vector, 3 machine address, 4 machine cause, 5 supervisor vector, 6 supervisor address, 7 supervisor cause. A write is visible after the next edge. A trap in the same cycle overrides a write to any register the trap updates.
- R11: Exception bits 8, 9, 10, 11 and 14 and interrupt lines 2, 6 and 10 are ignored: they alone cause no trap and change no register.
- R12: Writing 10 into the machine status field stores 00, so that field never holds 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_i | input | NEXC | Raised exception flags, bit n = code n |
| ecall_i | input | 1 | Environment-call request |
| irq_i | input | NIRQ | Pending and enabled interrupt lines, bit n = code n |
| pc_i | input | XLEN | Address of the instruction in question |
| mret_i | input | 1 | Machine return request |
| sret_i | input | 1 | Supervisor return request |
| csr_we_i | input | 1 | Register write strobe |
| csr_idx_i | input | 3 | Register index for the write |
| csr_wdata_i | input | XLEN | Register write data |
| trap_o | output | 1 | A trap is taken this cycle |
| trap_s_o | output | 1 | The trap is taken in supervisor mode |
| redirect_o | output | 1 | The PC is redirected this cycle |
| target_pc_o | output | XLEN | New PC when redirect_o is high, else zero |
| priv_o | output | 2 | Current privilege |
| mcause_o | output | XLEN | Machine cause register |
| mepc_o | output | XLEN | Machine exception address |
| scause_o | output | XLEN | Supervisor cause register |
| sepc_o | output | XLEN | Supervisor exception address |
| mpp_o | output | 2 | Saved machine previous privilege |
| spp_o | output | 1 | Saved supervisor previous privilege |

## Verification
Directed sequences walk the privilege from machine to user by a return, then raise environment calls from user and supervisor. This separates the mode-dependent codes and the delegated path from the machine-only path. Pairs of simultaneous flags show whether the priority chain is wired in the right order. An exception raised together with an interrupt shows whether the synchronous side wins. Interrupt-only traps taken under a full delegation mask show that interrupts are never delegated. Random flag, interrupt, return and write mixes, with a fixed seed, stress the overlaps: a trap arriving together with a write to its own registers, and a return arriving together with a status write.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [1:0] {
      PRV_U = 2'b00,
      PRV_S = 2'b01,
      PRV_M = 2'b11
   } prv_e;

   typedef enum logic [2:0] {
      REG_STATUS = 3'd0,
      REG_DELEG  = 3'd1,
      REG_MVEC   = 3'd2,
      REG_MEPC   = 3'd3,
      REG_MCAUSE = 3'd4,
      REG_SVEC   = 3'd5,
      REG_SEPC   = 3'd6,
      REG_SCAUSE = 3'd7
   } reg_idx_e;

   // environment-call slot in the flag vector and its per-mode codes
   localparam int unsigned ECALL_SLOT = 8;
   localparam int unsigned ECODE_U    = 8;
   localparam int unsigned ECODE_S    = 9;
   localparam int unsigned ECODE_M    = 11;

   // synchronous priority list, highest first
   localparam int unsigned NPRI = 12;
   localparam int unsigned SYNC_ORDER [NPRI] = '{3, 0, 1, 12, 2, 8, 4, 6, 13, 15, 5, 7};

   localparam logic [15:0] SYNC_VALID = 16'hB0FF;
   localparam logic [11:0] IRQ_VALID  = 12'hBBB;
endpackage

// File: rtl/trap_prio.sv
module trap_prio
   import trap_pkg::*;
#(
   parameter int unsigned NEXC = 16,
   parameter int unsigned NIRQ = 12,
   parameter int unsigned CW   = 4
) (
   input  logic [NEXC-1:0] exc_i,
   input  logic            ecall_i,
   input  logic [1:0]      priv_i,
   input  logic [NIRQ-1:0] irq_i,
   output logic            take_o,
   output logic            irq_o,
   output logic [CW-1:0]   code_o
);
   if (NEXC != 16) begin : g_bad_nexc
      $error("trap_prio: NEXC must be 16");
   end
   if (NIRQ != 12) begin : g_bad_nirq
      $error("trap_prio: NIRQ must be 12");
   end
   if (CW < 4) begin : g_bad_cw
      $error("trap_prio: CW must hold code 15");
   end

   logic [NEXC-1:0] exc_eff;
   logic [NIRQ-1:0] irq_eff;
   logic            sync_hit;
   logic [CW-1:0]   scode;
   logic [CW-1:0]   icode;

   always_comb begin
      exc_eff             = exc_i & SYNC_VALID;
      exc_eff[ECALL_SLOT] = ecall_i;
      sync_hit            = 1'b0;
      scode               = '0;
      // walk from lowest priority up so the highest hit is kept
      for (int k = NPRI - 1; k >= 0; k--) begin
         if (exc_eff[SYNC_ORDER[k]]) begin
            sync_hit = 1'b1;
            scode    = CW'(SYNC_ORDER[k]);
         end
      end
      if (sync_hit && (scode == CW'(ECALL_SLOT))) begin
         unique case (priv_i)
            PRV_U:   scode = CW'(ECODE_U);
            PRV_S:   scode = CW'(ECODE_S);
            default: scode = CW'(ECODE_M);
         endcase
      end
   end

   always_comb begin
      irq_eff = irq_i & IRQ_VALID;
      icode   = '0;
      for (int i = 0; i < NIRQ; i++) begin
         if (irq_eff[i]) icode = CW'(i);
      end
   end

   assign take_o = sync_hit | (|irq_eff);
   assign irq_o  = !sync_hit && (|irq_eff);
   assign code_o = sync_hit ? scode : icode;
endmodule

// File: rtl/trap_route.sv
module trap_route
   import trap_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned NEXC     = 16,
   parameter int unsigned CW       = 4,
   parameter bit          DELEG_EN = 1'b1
) (
   input  logic            take_i,
   input  logic            irq_i,
   input  logic [CW-1:0]   code_i,
   input  logic [1:0]      priv_i,
   input  logic [NEXC-1:0] deleg_i,
   input  logic [XLEN-1:0] mvec_i,
   input  logic [XLEN-1:0] svec_i,
   output logic            to_s_o,
   output logic [XLEN-1:0] vec_o
);
   if ((1 << CW) > NEXC) begin : g_bad_cw
      $error("trap_route: code range exceeds delegation mask");
   end

   if (DELEG_EN) begin : g_deleg
      // machine-mode traps never move down; interrupts never delegate
      assign to_s_o = take_i && !irq_i && (priv_i != PRV_M) && deleg_i[code_i];
   end else begin : g_no_deleg
      logic unused_deleg;
      assign unused_deleg = ^{irq_i, code_i, priv_i, deleg_i};
      assign to_s_o       = 1'b0;
   end

   assign vec_o = to_s_o ? svec_i : mvec_i;
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
   import trap_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned NEXC = 16,
   parameter int unsigned NIRQ = 12,
   parameter int unsigned CW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NEXC-1:0] exc_i,
   input  logic            ecall_i,
   input  logic [NIRQ-1:0] irq_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic            mret_i,
   input  logic            sret_i,
   input  logic            csr_we_i,
   input  logic [2:0]      csr_idx_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   output logic            trap_o,
   output logic            trap_s_o,
   output logic            redirect_o,
   output logic [XLEN-1:0] target_pc_o,
   output logic [1:0]      priv_o,
   output logic [XLEN-1:0] mcause_o,
   output logic [XLEN-1:0] mepc_o,
   output logic [XLEN-1:0] scause_o,
   output logic [XLEN-1:0] sepc_o,
   output logic [1:0]      mpp_o,
   output logic            spp_o
);
   if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("trap_ctl: XLEN must be 32 or 64");
   end

   localparam int unsigned PADW = XLEN - 1 - CW;

   logic            take, is_irq, to_s;
   logic [CW-1:0]   code;
   logic [XLEN-1:0] vec, cause;
   logic [1:0]      priv_q, mpp_q;
   logic            spp_q;
   logic [NEXC-1:0] deleg_q;
   logic [XLEN-1:0] mvec_q, svec_q, mepc_q, sepc_q, mcause_q, scause_q;
   logic [1:0]      wr_mpp;

   trap_prio #(.NEXC(NEXC), .NIRQ(NIRQ), .CW(CW)) u_prio (
      .exc_i   (exc_i),
      .ecall_i (ecall_i),
      .priv_i  (priv_q),
      .irq_i   (irq_i),
      .take_o  (take),
      .irq_o   (is_irq),
      .code_o  (code)
   );

   trap_route #(.XLEN(XLEN), .NEXC(NEXC), .CW(CW), .DELEG_EN(1'b1)) u_route (
      .take_i  (take),
      .irq_i   (is_irq),
      .code_i  (code),
      .priv_i  (priv_q),
      .deleg_i (deleg_q),
      .mvec_i  (mvec_q),
      .svec_i  (svec_q),
      .to_s_o  (to_s),
      .vec_o   (vec)
   );

   // interrupt flag lands on the top bit for either width
   assign cause  = {is_irq, {PADW{1'b0}}, code};
   assign wr_mpp = (csr_wdata_i[12:11] == 2'b10) ? 2'b00 : csr_wdata_i[12:11];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         priv_q   <= PRV_M;
         mpp_q    <= PRV_U;
         spp_q    <= 1'b0;
         deleg_q  <= '0;
         mvec_q   <= '0;
         svec_q   <= '0;
         mepc_q   <= '0;
         sepc_q   <= '0;
         mcause_q <= '0;
         scause_q <= '0;
      end else begin
         if (csr_we_i) begin
            unique case (csr_idx_i)
               REG_STATUS: begin
                  mpp_q <= wr_mpp;
                  spp_q <= csr_wdata_i[8];
               end
               REG_DELEG:  deleg_q  <= csr_wdata_i[NEXC-1:0];
               REG_MVEC:   mvec_q   <= {csr_wdata_i[XLEN-1:2], 2'b00};
               REG_MEPC:   mepc_q   <= csr_wdata_i;
               REG_MCAUSE: mcause_q <= csr_wdata_i;
               REG_SVEC:   svec_q   <= {csr_wdata_i[XLEN-1:2], 2'b00};
               REG_SEPC:   sepc_q   <= csr_wdata_i;
               default:    scause_q <= csr_wdata_i;
            endcase
         end
         // trap and return updates come last so they override the write
         if (take) begin
            if (to_s) begin
               scause_q <= cause;
               sepc_q   <= pc_i;
               spp_q    <= priv_q[0];
               priv_q   <= PRV_S;
            end else begin
               mcause_q <= cause;
               mepc_q   <= pc_i;
               mpp_q    <= priv_q;
               priv_q   <= PRV_M;
            end
         end else if (mret_i) begin
            priv_q <= mpp_q;
            mpp_q  <= PRV_U;
         end else if (sret_i) begin
            priv_q <= {1'b0, spp_q};
            spp_q  <= 1'b0;
         end
      end
   end

   assign trap_o      = take;
   assign trap_s_o    = to_s;
   assign redirect_o  = take | mret_i | sret_i;
   assign target_pc_o = take   ? vec    :
                        mret_i ? mepc_q :
                        sret_i ? sepc_q : '0;
   assign priv_o      = priv_q;
   assign mcause_o    = mcause_q;
   assign mepc_o      = mepc_q;
   assign scause_o    = scause_q;
   assign sepc_o      = sepc_q;
   assign mpp_o       = mpp_q;
   assign spp_o       = spp_q;

   AST_M_NOT_DELEGATED: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && priv_o == PRV_M) |-> !trap_s_o) else $error("machine trap delegated"); // R5
   AST_IRQ_TO_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && is_irq) |-> !trap_s_o) else $error("interrupt delegated"); // R5
   AST_IRQ_FLAG_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (take && is_irq) |=> mcause_o[XLEN-1]) else $error("interrupt flag missing"); // R4
   AST_MTRAP_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && !trap_s_o) |=> (priv_o == PRV_M && mepc_o == $past(pc_i))) else $error("machine trap state"); // R6
   AST_STRAP_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && trap_s_o) |=> (priv_o == PRV_S && sepc_o == $past(pc_i))) else $error("supervisor trap state"); // R6
   AST_MRET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (mret_i && !trap_o) |=> (priv_o == $past(mpp_o) && mpp_o == PRV_U)) else $error("machine return"); // R8
   AST_SRET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (sret_i && !mret_i && !trap_o) |=> (priv_o == {1'b0, $past(spp_o)} && !spp_o)) else $error("supervisor return"); // R9
   AST_MPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mpp_o != 2'b10) else $error("illegal saved privilege"); // R12
endmodule

// File: tb/sim_trap_ctl.sv
`timescale 1ns/1ps
module sim_trap_ctl;
   localparam int XL = 32;
   localparam int unsigned ORDER [12] = '{3, 0, 1, 12, 2, 8, 4, 6, 13, 15, 5, 7};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   exc_i = '0;
   logic          ecall_i = 1'b0;
   logic [11:0]   irq_i = '0;
   logic [XL-1:0] pc_i = '0;
   logic          mret_i = 1'b0, sret_i = 1'b0, csr_we_i = 1'b0;
   logic [2:0]    csr_idx_i = '0;
   logic [XL-1:0] csr_wdata_i = '0;
   logic          trap_o, trap_s_o, redirect_o, spp_o;
   logic [XL-1:0] target_pc_o, mcause_o, mepc_o, scause_o, sepc_o;
   logic [1:0]    priv_o, mpp_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model of architectural state
   logic [1:0]    m_priv = 2'b11, m_mpp = 2'b00;
   logic          m_spp = 1'b0;
   logic [15:0]   m_deleg = '0;
   logic [XL-1:0] m_mvec = '0, m_svec = '0, m_mepc = '0, m_sepc = '0, m_mcause = '0, m_scause = '0;

   always #4 clk = ~clk;

   trap_ctl #(.XLEN(XL)) u0 (
      .clk(clk), .rst_n(rst_n), .exc_i(exc_i), .ecall_i(ecall_i), .irq_i(irq_i),
      .pc_i(pc_i), .mret_i(mret_i), .sret_i(sret_i), .csr_we_i(csr_we_i),
      .csr_idx_i(csr_idx_i), .csr_wdata_i(csr_wdata_i), .trap_o(trap_o),
      .trap_s_o(trap_s_o), .redirect_o(redirect_o), .target_pc_o(target_pc_o),
      .priv_o(priv_o), .mcause_o(mcause_o), .mepc_o(mepc_o), .scause_o(scause_o),
      .sepc_o(sepc_o), .mpp_o(mpp_o), .spp_o(spp_o)
   );

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // returns {take, is_irq, code[3:0]}
   function automatic logic [5:0] pick(input logic [15:0] exc, input logic ec,
                                       input logic [11:0] irq, input logic [1:0] pv);
      logic [15:0] e;
      logic [11:0] q;
      e = exc & 16'hB0FF;
      e[8] = ec;
      for (int k = 0; k < 12; k++) begin
         if (e[ORDER[k]]) begin
            if (ORDER[k] == 8) return {2'b10, (pv == 2'b00) ? 4'd8 : (pv == 2'b01) ? 4'd9 : 4'd11};
            return {2'b10, 4'(ORDER[k])};
         end
      end
      q = irq & 12'hBBB;
      for (int i = 11; i >= 0; i--) begin
         if (q[i]) return {2'b11, 4'(i)};
      end
      return 6'd0;
   endfunction

   task automatic check_regs(input string tag);
      chk(tag, "priv", 64'(priv_o), 64'(m_priv));
      chk(tag, "mcause", 64'(mcause_o), 64'(m_mcause));
      chk(tag, "mepc", 64'(mepc_o), 64'(m_mepc));
      chk(tag, "scause", 64'(scause_o), 64'(m_scause));
      chk(tag, "sepc", 64'(sepc_o), 64'(m_sepc));
      chk(tag, "mpp", 64'(mpp_o), 64'(m_mpp));
      chk(tag, "spp", 64'(spp_o), 64'(m_spp));
   endtask

   task automatic step(input string tag, input logic [15:0] exc, input logic ec, input logic [11:0] irq,
                       input logic [XL-1:0] pc, input logic mr, input logic sr,
                       input logic we, input logic [2:0] idx, input logic [XL-1:0] wd);
      logic [5:0]    p;
      logic          to_s;
      logic [XL-1:0] cause, tpc;
      logic [1:0]    o_priv, o_mpp;
      logic          o_spp;
      @(negedge clk);
      exc_i = exc; ecall_i = ec; irq_i = irq; pc_i = pc; mret_i = mr; sret_i = sr;
      csr_we_i = we; csr_idx_i = idx; csr_wdata_i = wd;
      p     = pick(exc, ec, irq, m_priv);
      to_s  = p[5] && !p[4] && (m_priv != 2'b11) && m_deleg[p[3:0]];
      cause = {p[4], 27'd0, p[3:0]};
      tpc   = p[5] ? (to_s ? m_svec : m_mvec) : mr ? m_mepc : sr ? m_sepc : '0;
      #1;
      chk(tag, "trap", 64'(trap_o), 64'(p[5]));
      chk(tag, "trap_s", 64'(trap_s_o), 64'(to_s));
      chk(tag, "redirect", 64'(redirect_o), 64'(p[5] | mr | sr));
      chk(tag, "target_pc", 64'(target_pc_o), 64'(tpc));
      o_priv = m_priv; o_mpp = m_mpp; o_spp = m_spp;
      if (we) begin
         case (idx)
            3'd0: begin m_mpp = (wd[12:11] == 2'b10) ? 2'b00 : wd[12:11]; m_spp = wd[8]; end
            3'd1: m_deleg  = wd[15:0];
            3'd2: m_mvec   = {wd[XL-1:2], 2'b00};
            3'd3: m_mepc   = wd;
            3'd4: m_mcause = wd;
            3'd5: m_svec   = {wd[XL-1:2], 2'b00};
            3'd6: m_sepc   = wd;
            default: m_scause = wd;
         endcase
      end
      if (p[5]) begin
         if (to_s) begin m_scause = cause; m_sepc = pc; m_spp = o_priv[0]; m_priv = 2'b01; end
         else begin m_mcause = cause; m_mepc = pc; m_mpp = o_priv; m_priv = 2'b11; end
      end else if (mr) begin
         m_priv = o_mpp; m_mpp = 2'b00;
      end else if (sr) begin
         m_priv = {1'b0, o_spp}; m_spp = 1'b0;
      end
      @(posedge clk);
      #1;
      exc_i = '0; ecall_i = 1'b0; irq_i = '0; mret_i = 1'b0; sret_i = 1'b0; csr_we_i = 1'b0;
      check_regs(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: reset state
      check_regs("R1");
      chk("R1", "trap_idle", 64'(trap_o), 64'd0);

      // R3: environment call from machine mode gives code 11
      step("R3", 16'h0, 1'b1, 12'h0, 32'h100, 0, 0, 0, 3'd0, 0);
      // R12: writing 10 into machine field keeps 00
      step("R12", 16'h0, 1'b0, 12'h0, 0, 0, 0, 1, 3'd0, 32'h0000_1000);
      // R7: vector bases drop their low bits
      step("R7", 16'h0, 1'b0, 12'h0, 0, 0, 0, 1, 3'd2, 32'h8000_0103);
      step("R7", 16'h0, 1'b0, 12'h0, 0, 0, 0, 1, 3'd5, 32'h4000_0002);
      step("R10", 16'h0, 1'b0, 12'h0, 0, 0, 0, 1, 3'd1, 32'h0000_FFFF);
      // R8: machine return to user
      step("R8", 16'h0, 1'b0, 12'h0, 0, 1, 0, 0, 3'd0, 0);
      // R5: delegated environment call from user, code 8
      step("R5", 16'h0, 1'b1, 12'h0, 32'h200, 0, 0, 0, 3'd0, 0);
      // R3: environment call from supervisor gives code 9
      step("R3", 16'h0, 1'b1, 12'h0, 32'h204, 0, 0, 0, 3'd0, 0);
      // R9: supervisor return twice: to supervisor, then to user
      step("R9", 16'h0, 1'b0, 12'h0, 0, 0, 1, 0, 3'd0, 0);
      step("R9", 16'h0, 1'b0, 12'h0, 0, 0, 1, 0, 3'd0, 0);
      // R4: exception beats interrupt, delegated from user
      step("R4", 16'h0010, 1'b0, 12'h080, 32'h300, 0, 0, 0, 3'd0, 0);
      step("R9", 16'h0, 1'b0, 12'h0, 0, 0, 1, 0, 3'd0, 0);
      // R4: interrupt alone, highest line, never delegated
      step("R4", 16'h0, 1'b0, 12'h088, 32'h304, 0, 0, 0, 3'd0, 0);
      // R2: priority pairs taken from machine mode
      step("R2", 16'h000C, 1'b0, 12'h0, 32'h400, 0, 0, 0, 3'd0, 0);
      step("R2", 16'h0014, 1'b0, 12'h0, 32'h404, 0, 0, 0, 3'd0, 0);
      step("R2", 16'h2020, 1'b0, 12'h0, 32'h408, 0, 0, 0, 3'd0, 0);
      step("R2", 16'h1004, 1'b0, 12'h0, 32'h40C, 0, 0, 0, 3'd0, 0);
      step("R2", 16'h0014, 1'b1, 12'h0, 32'h410, 0, 0, 0, 3'd0, 0);
      // R11: ignored flags and lines
      step("R11", 16'h4F00, 1'b0, 12'h0, 32'h500, 0, 0, 0, 3'd0, 0);
      step("R11", 16'h0, 1'b0, 12'h444, 32'h504, 0, 0, 0, 3'd0, 0);
      // R10: write visible next cycle; trap overrides a same-cycle write
      step("R10", 16'h0, 1'b0, 12'h0, 0, 0, 0, 1, 3'd3, 32'h0000_1234);
      step("R10", 16'h0004, 1'b0, 12'h0, 32'h600, 0, 0, 1, 3'd4, 32'h0000_0055);
      // R6: machine trap from supervisor saves 01
      step("R6", 16'h0, 1'b0, 12'h0, 0, 0, 0, 1, 3'd0, 32'h0000_0800);
      step("R6", 16'h0, 1'b0, 12'h0, 0, 1, 0, 0, 3'd0, 0);
      step("R6", 16'h0, 1'b0, 12'h800, 32'h700, 0, 0, 0, 3'd0, 0);
      step("R1", 16'h0, 1'b0, 12'h0, 0, 0, 0, 1, 3'd1, 32'h0);

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         logic [15:0] e;
         logic [11:0] q;
         logic mr, sr;
         e  = ($urandom % 3 == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
         q  = ($urandom % 3 == 0) ? 12'($urandom) : 12'h0;
         mr = ($urandom % 6 == 0);
         sr = !mr && ($urandom % 6 == 0);
         step("R5", e, ($urandom % 6 == 0), q, $urandom & 32'hFFFF_FFFC, mr, sr,
              ($urandom % 4 == 0), 3'($urandom), $urandom);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule